// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a logical memory reference, presented as a page number and a byte displacement, into a physical address. It keeps a small table indexed directly by page number. Each entry holds a valid bit and the full physical base address of a resident page. For a resident page, the physical address is the stored base plus the displacement. The base is added, not concatenated, so a page may start at any byte address.

Requests arrive one per cycle on a valid/ready handshake. Each accepted request produces exactly one registered response one cycle later. The response carries exactly one of three outcomes:

- a hit, with its physical address;
- a page fault, when the entry is not valid;
- an illegal address, when the displacement is not below the 1024-byte page size.

A separate write port loads or invalidates single entries. The block only reports faults and never fills the table itself. Whatever services faults uses this write port.

Top module: `page_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1 from the first cycle after reset is released, and every table entry is invalid, so any in-range lookup reports a fault.
- R2: A lookup whose displacement is below 1024 and whose entry is valid gives `rsp_hit`=1 and `rsp_paddr` = stored base + displacement, computed to 17 bits with no wrap (base 65535 + 1023 = 66558).
- R3: A lookup whose displacement is below 1024 and whose entry is invalid gives `rsp_fault`=1 and `rsp_paddr`=0.
- R4: A lookup whose displacement is 1024 or more gives `rsp_illegal`=1 and `rsp_paddr`=0, whether the entry is valid or not (illegal takes priority over fault).
- R5: Every response has exactly one of `rsp_hit`, `rsp_fault` and `rsp_illegal` set.
- R6: `rsp_valid` pulses high in the cycle after each accepted request (`req_valid` and `req_ready` both high), and at no other time. Back-to-back requests give back-to-back responses in order.
- R7: A table write in the same cycle as a lookup of the same index does not affect that lookup, which sees the old entry. The new entry is seen from the next cycle.
- R8: A write with `wr_valid`=0 invalidates the entry, so later in-range lookups of that page fault.
- R9: Entries are selected by page number alone (entry index = `req_page`), and a write changes only the entry named by `wr_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_page | input | 4 | Page number of the reference |
| req_disp | input | 11 | Byte displacement within the page |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 4 | Entry to write |
| wr_base | input | 16 | Physical base address to store |
| wr_valid | input | 1 | Valid bit to store (0 invalidates) |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Page not resident |
| rsp_illegal | output | 1 | Displacement outside the page |
| rsp_paddr | output | 17 | Physical address (0 unless hit) |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a table write and a lookup of the same index. The bench issues both in one cycle, on both a fresh page and an overwritten page. It expects the old entry in that response and the new entry in the lookup that follows at once. The second pair is an oversized displacement on a non-resident page. The bench presents displacement 1024 and larger to unloaded pages and expects the illegal flag alone, never the fault flag. A scoreboard computes every expected outcome from its own copy of the table and updates that copy only after it has queued the same-cycle lookup.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  typedef enum logic [1:0] {
    OUT_HIT     = 2'd0,
    OUT_FAULT   = 2'd1,
    OUT_ILLEGAL = 2'd2
  } outcome_e;
endpackage

// File: rtl/pgx_table.sv
module pgx_table #(
  parameter int PAGES  = 16,
  parameter int BASE_W = 16,
  localparam int IDX_W = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic              rd_vld
);
  logic [PAGES-1:0]  vld_q;
  logic [BASE_W-1:0] base_q [PAGES];

  for (genvar g = 0; g < PAGES; g++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g]  <= 1'b0;
        base_q[g] <= '0;
      end else if (sel) begin
        vld_q[g]  <= wr_valid;
        base_q[g] <= wr_base;
      end
    end
  end

  // Read side sees the stored state, so a same-cycle write is not visible yet.
  assign rd_base = base_q[rd_idx];
  assign rd_vld  = vld_q[rd_idx];

  // R8
  wr_vld_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q[$past(wr_idx)] == $past(wr_valid)));

  // R9
  no_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vld_q));
endmodule

// File: rtl/pgx_classify.sv
module pgx_classify
  import pgx_pkg::*;
#(
  parameter int BASE_W     = 16,
  parameter int DISP_W     = 11,
  parameter int PAGE_BYTES = 1024,
  localparam int PADDR_W   = ((BASE_W > DISP_W) ? BASE_W : DISP_W) + 1
) (
  input  logic [DISP_W-1:0]  disp,
  input  logic               ent_vld,
  input  logic [BASE_W-1:0]  ent_base,
  output outcome_e           outcome,
  output logic [PADDR_W-1:0] paddr
);
  localparam logic [DISP_W-1:0] LIMIT = DISP_W'(PAGE_BYTES);

  function automatic logic disp_out_of_page(input logic [DISP_W-1:0] d);
    return d >= LIMIT;
  endfunction

  function automatic logic [PADDR_W-1:0] form_paddr(
    input logic [BASE_W-1:0] b, input logic [DISP_W-1:0] d);
    return PADDR_W'(b) + PADDR_W'(d);
  endfunction

  logic bad_disp;
  assign bad_disp = disp_out_of_page(disp);

  always_comb begin
    paddr = '0;
    if (bad_disp) begin
      outcome = OUT_ILLEGAL;
    end else if (!ent_vld) begin
      outcome = OUT_FAULT;
    end else begin
      outcome = OUT_HIT;
      paddr   = form_paddr(ent_base, disp);
    end
  end
endmodule

// File: rtl/pgx_resp_reg.sv
module pgx_resp_reg
  import pgx_pkg::*;
#(
  parameter int PADDR_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  outcome_e           outcome,
  input  logic [PADDR_W-1:0] paddr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_fault,
  output logic               rsp_illegal,
  output logic [PADDR_W-1:0] rsp_paddr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_paddr   <= '0;
    end else begin
      rsp_valid   <= take;
      rsp_hit     <= take && (outcome == OUT_HIT);
      rsp_fault   <= take && (outcome == OUT_FAULT);
      rsp_illegal <= take && (outcome == OUT_ILLEGAL);
      rsp_paddr   <= take ? paddr : '0;
    end
  end

  // R5
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_fault, rsp_illegal}) == 1));

  // R3
  zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0));
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import pgx_pkg::*;
#(
  parameter int PAGES      = 16,
  parameter int BASE_W     = 16,
  parameter int DISP_W     = 11,
  parameter int PAGE_BYTES = 1024,
  localparam int IDX_W     = $clog2(PAGES),
  localparam int PADDR_W   = ((BASE_W > DISP_W) ? BASE_W : DISP_W) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [IDX_W-1:0]   req_page,
  input  logic [DISP_W-1:0]  req_disp,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [BASE_W-1:0]  wr_base,
  input  logic               wr_valid,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_fault,
  output logic               rsp_illegal,
  output logic [PADDR_W-1:0] rsp_paddr
);
  logic [BASE_W-1:0]  ent_base;
  logic               ent_vld;
  outcome_e           outcome;
  logic [PADDR_W-1:0] paddr_c;
  logic               accept;
  logic               ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign req_ready = ready_q;
  assign accept    = req_valid && req_ready;

  pgx_table #(.PAGES(PAGES), .BASE_W(BASE_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base), .wr_valid(wr_valid),
    .rd_idx(req_page), .rd_base(ent_base), .rd_vld(ent_vld)
  );

  pgx_classify #(.BASE_W(BASE_W), .DISP_W(DISP_W), .PAGE_BYTES(PAGE_BYTES)) u_class (
    .disp(req_disp), .ent_vld(ent_vld), .ent_base(ent_base),
    .outcome(outcome), .paddr(paddr_c)
  );

  pgx_resp_reg #(.PADDR_W(PADDR_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .take(accept), .outcome(outcome), .paddr(paddr_c),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_illegal(rsp_illegal), .rsp_paddr(rsp_paddr)
  );

  // R6
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R6
  rsp_only_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_valid);

  // R4
  illegal_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_disp >= DISP_W'(PAGE_BYTES))) |=> rsp_illegal);

  // R7
  old_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_disp < DISP_W'(PAGE_BYTES)) && !ent_vld) |=> rsp_fault);
endmodule

// File: tb/sim_page_xlate.sv
module sim_page_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_page = '0;
  logic [10:0] req_disp = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [15:0] wr_base = '0;
  logic        wr_valid = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_illegal;
  logic [16:0] rsp_paddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_disp(req_disp), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_base(wr_base), .wr_valid(wr_valid), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_illegal(rsp_illegal),
    .rsp_paddr(rsp_paddr)
  );

  typedef struct {
    logic [2:0]  flags;   // {hit, fault, illegal}
    logic [16:0] paddr;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [15:0] m_base [16];
  logic        m_vld  [16];

  function automatic exp_t predict(input logic [3:0] pg, input logic [10:0] d, input string tag);
    exp_t e;
    e.req = tag;
    e.paddr = '0;
    if (d >= 11'd1024)  e.flags = 3'b001;
    else if (!m_vld[pg]) e.flags = 3'b010;
    else begin
      e.flags = 3'b100;
      e.paddr = {1'b0, m_base[pg]} + {6'd0, d};
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // Driver: one cycle, optional lookup and optional write together.
  task automatic cyc(input bit lk, input logic [3:0] pg, input logic [10:0] d,
                     input bit wr, input logic [3:0] wi, input logic [15:0] wb,
                     input bit wv, input string tag);
    @(negedge clk);
    req_valid = lk; req_page = pg; req_disp = d;
    wr_en = wr; wr_idx = wi; wr_base = wb; wr_valid = wv;
    if (lk) sb.push_back(predict(pg, d, tag));
    if (wr) begin m_vld[wi] = wv; m_base[wi] = wb; end
  endtask

  task automatic look(input logic [3:0] pg, input logic [10:0] d, input string tag);
    cyc(1'b1, pg, d, 1'b0, 4'd0, 16'd0, 1'b0, tag);
  endtask

  task automatic load(input logic [3:0] wi, input logic [15:0] wb, input bit wv);
    cyc(1'b0, 4'd0, 11'd0, 1'b1, wi, wb, wv, "");
  endtask

  task automatic idle();
    cyc(1'b0, 4'd0, 11'd0, 1'b0, 4'd0, 16'd0, 1'b0, "");
  endtask

  // Monitor: pops one expected item per response pulse.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R6 unexpected response", "rsp_valid=1", "rsp_valid=0");
      end else begin
        exp_t e;
        logic [2:0] got;
        e = sb.pop_front();
        got = {rsp_hit, rsp_fault, rsp_illegal};
        check(got == e.flags && rsp_paddr == e.paddr, e.req,
              $sformatf("flags=%b paddr=%0d", got, rsp_paddr),
              $sformatf("flags=%b paddr=%0d", e.flags, e.paddr));
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_vld[i] = 1'b0; m_base[i] = '0; end
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp_valid in reset", $sformatf("%b", rsp_valid), "0");
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 req_ready after reset", $sformatf("%b", req_ready), "1");
    check(rsp_valid == 1'b0, "R1 rsp_valid idle", $sformatf("%b", rsp_valid), "0");

    look(4'd0, 11'd0, "R1 empty page 0 faults");
    look(4'd15, 11'd1023, "R1 empty page 15 faults");

    load(4'd7, 16'd3000, 1'b1);
    load(4'd12, 16'd9000, 1'b1);
    load(4'd10, 16'd4000, 1'b1);
    load(4'd5, 16'd8000, 1'b1);
    load(4'd9, 16'd6000, 1'b1);
    load(4'd1, 16'd2000, 1'b1);
    load(4'd15, 16'd65535, 1'b1);

    look(4'd7, 11'd200, "R2 page 7 disp 200");
    look(4'd12, 11'd100, "R9 page 12 disp 100");
    look(4'd11, 11'd800, "R3 page 11 not loaded");
    look(4'd4, 11'd900, "R3 page 4 not loaded");
    look(4'd10, 11'd1100, "R4 disp 1100 on loaded page");
    look(4'd11, 11'd1024, "R4 illegal beats fault");
    look(4'd3, 11'd2047, "R4 max disp on empty page");
    look(4'd10, 11'd1023, "R2 last byte of page");
    look(4'd5, 11'd0, "R2 first byte of page");
    look(4'd15, 11'd1023, "R2 no wrap at top");
    idle();

    // Same-cycle write and lookup of one index
    cyc(1'b1, 4'd3, 11'd5, 1'b1, 4'd3, 16'd100, 1'b1, "R7 fresh page old view");
    look(4'd3, 11'd5, "R7 fresh page new view");
    cyc(1'b1, 4'd7, 11'd1, 1'b1, 4'd7, 16'd500, 1'b1, "R7 overwrite old view");
    look(4'd7, 11'd1, "R7 overwrite new view");
    look(4'd9, 11'd10, "R9 neighbour untouched");

    load(4'd12, 16'd9000, 1'b0);
    look(4'd12, 11'd100, "R8 invalidated page faults");
    look(4'd1, 11'd0, "R9 other page still hits");
    idle(); idle();

    for (int i = 0; i < 48; i++) begin
      if (i % 5 == 4) idle();
      else look(4'((i * 7) % 16), 11'((i * 97) % 1200), "R6 stream");
    end
    idle(); idle(); idle();
    check(sb.size() == 0, "R6 all responses seen",
          $sformatf("%0d pending", sb.size()), "0 pending");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule